// File: doc/BRIEF.md
# Stereo Codec Capture Controller

This block runs a serial stereo audio codec of the AC97 kind in record-only mode. It is clocked by the codec's 12.288 MHz bit clock and generates the frame marker. It also shifts out a short fixed series of register-write commands that set up the codec's volume, gain and input source. After that it pulls the left and right microphone samples out of every incoming frame.

Each 20-bit sample is cut to its upper 16 bits and offered to an external FIFO through a plain write port with a full input. When the FIFO is full, that sample is dropped and the frame timing carries on. A start level arrives from another clock domain and passes through two flops. Until it arrives the serial link stays silent.

Top module: `codec_capture_ctl`

## Requirements
- R1: While reset is asserted and straight after it, `sync`, `sdata_out` and `fifo_wr_en` are all 0.
- R2: While `start_async` has never been high, `sync` and `sdata_out` stay 0 and no FIFO write occurs.
- R3: `start_async` passes through a two-flop synchronizer. If it is first sampled high at rising edge n, `sync` goes high after rising edge n+2, and that cycle is bit 0 of the first frame.
- R4: A frame is 256 bit clocks: a 16-bit tag slot, then twelve 20-bit slots. `sync` is high for exactly the 16 tag bits of every frame.
- R5: Serial bits leave MSB first and change after rising edges. Tag bit 15 (the first bit) is always 1. Tag bits 14 and 13 are 1 only in command frames. Every other tag bit is 0, and so is every bit of slots 3 to 12 on the output.
- R6: In command frames, slot 1 holds {0, addr[6:0], 12'b0} and slot 2 holds {data[15:0], 4'b0}. Outside command frames both slots are 0. Four commands go out in this order, one per frame starting with the first frame: (0x02,0x0000), (0x0E,0x0008), (0x1A,0x0000), (0x1C,0x0F0F).
- R7: No FIFO write happens during the four command frames. Capture starts with the frame that follows them and continues in every later frame.
- R8: `sdata_in` is sampled on falling edges. Input slot 3 is the left sample and slot 4 the right. Each is written as its upper 16 bits, as a one-cycle `fifo_wr_en` pulse. The left pulse is in frame bit 76 and the right pulse in frame bit 96.
- R9: If `fifo_full` is high at the edge where a sample would be written, that sample is dropped with no write. The other sample and the frame timing are not affected.
- R10: Input tag bits and input slots 1, 2 and 5 to 12 have no effect on the written samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_async | input | 1 | Start level from another clock domain |
| sdata_in | input | 1 | Serial data from the codec |
| sync | output | 1 | Frame marker to the codec |
| sdata_out | output | 1 | Serial command data to the codec |
| fifo_full | input | 1 | FIFO full flag |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 16 | Sample written to the FIFO |

## Verification
Capture is driven with several left/right pairs:
- Distinct nonzero patterns show whether left and right are swapped or shifted by a bit.
- A pair of all-zero and all-ones samples shows whether the upper 16 bits are kept.
- Ones in every ignored slot and tag bit, with zero samples, expose any read outside slots 3 and 4.

Raising full at the left sample only, and then at the right sample only, shows whether a drop is confined to that one sample. Command frames are fed nonzero sample slots to show that writing waits for the end of configuration.

// File: rtl/codec_capture_ctl.sv
module codec_capture_ctl #(
  parameter int TAG_W      = 16,
  parameter int SLOT_W     = 20,
  parameter int NUM_SLOTS  = 12,
  parameter int SAMPLE_W   = 16,
  parameter int LEFT_SLOT  = 3,
  parameter int RIGHT_SLOT = 4
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                start_async,
  input  logic                sdata_in,
  output logic                sync,
  output logic                sdata_out,
  input  logic                fifo_full,
  output logic                fifo_wr_en,
  output logic [SAMPLE_W-1:0] fifo_wr_data
);
  localparam int FRAME_W = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int POS_W   = $clog2(FRAME_W);
  localparam int N_CMDS  = 4;
  localparam int IDX_W   = $clog2(N_CMDS);
  localparam int A_START = TAG_W;
  localparam int D_START = TAG_W + SLOT_W;
  localparam int L_END   = TAG_W + LEFT_SLOT * SLOT_W - 1;
  localparam int R_END   = TAG_W + RIGHT_SLOT * SLOT_W - 1;
  localparam logic [POS_W-1:0] LAST_P  = POS_W'(FRAME_W - 1);
  localparam logic [POS_W-1:0] L_END_P = POS_W'(L_END);
  localparam logic [POS_W-1:0] R_END_P = POS_W'(R_END);

  typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_CAP} state_t;

  function automatic logic [22:0] cmd_word(input logic [IDX_W-1:0] i);
    case (i)
      2'd0:    cmd_word = {7'h02, 16'h0000};
      2'd1:    cmd_word = {7'h0E, 16'h0008};
      2'd2:    cmd_word = {7'h1A, 16'h0000};
      default: cmd_word = {7'h1C, 16'h0F0F};
    endcase
  endfunction

  state_t             state;
  logic [POS_W-1:0]   pos;
  logic [IDX_W-1:0]   cmd_idx;
  logic               start_s1, start_s2;
  logic [SLOT_W-1:0]  rx_sh;

  wire running = (state != ST_IDLE);
  wire pending = (state == ST_CFG);
  wire [22:0] cmd = cmd_word(cmd_idx);
  wire [SLOT_W-1:0] addr_slot = {1'b0, cmd[22:16], 12'b0};
  wire [SLOT_W-1:0] data_slot = {cmd[15:0], 4'b0};

  assign sync = running && (int'(pos) < TAG_W);

  always_comb begin
    int p;
    p = int'(pos);
    sdata_out = 1'b0;
    if (running) begin
      if (p == 0)
        sdata_out = 1'b1;
      else if (p < 3)
        sdata_out = pending;
      else if (p >= A_START && p < D_START)
        sdata_out = pending && addr_slot[SLOT_W-1-(p-A_START)];
      else if (p >= D_START && p < D_START + SLOT_W)
        sdata_out = pending && data_slot[SLOT_W-1-(p-D_START)];
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      start_s1     <= 1'b0;
      start_s2     <= 1'b0;
      state        <= ST_IDLE;
      pos          <= '0;
      cmd_idx      <= '0;
      fifo_wr_en   <= 1'b0;
      fifo_wr_data <= '0;
    end else begin
      start_s1   <= start_async;
      start_s2   <= start_s1;
      fifo_wr_en <= 1'b0;
      if (state == ST_IDLE) begin
        pos <= '0;
        if (start_s2) state <= ST_CFG;
      end else begin
        pos <= (pos == LAST_P) ? '0 : pos + 1'b1;
        if (state == ST_CFG && pos == LAST_P) begin
          if (cmd_idx == IDX_W'(N_CMDS - 1)) state <= ST_CAP;
          else cmd_idx <= cmd_idx + 1'b1;
        end
        if (state == ST_CAP && (pos == L_END_P || pos == R_END_P) && !fifo_full) begin
          fifo_wr_en   <= 1'b1;
          fifo_wr_data <= rx_sh[SLOT_W-1 -: SAMPLE_W];
        end
      end
    end
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) rx_sh <= '0;
    else if (running) rx_sh <= {rx_sh[SLOT_W-2:0], sdata_in};
  end
endmodule

module codec_capture_ctl_chk #(
  parameter int N_CMDS = 4
) (
  input logic bit_clk,
  input logic rst_n,
  input logic start_async,
  input logic sync,
  input logic sdata_out,
  input logic fifo_full,
  input logic fifo_wr_en
);
  int  sync_run;
  int  rises;
  logic start_seen;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_run   <= 0;
      rises      <= 0;
      start_seen <= 1'b0;
    end else begin
      sync_run <= sync ? sync_run + 1 : 0;
      if (sync && sync_run == 0 && rises < 1000) rises <= rises + 1;
      if (start_async) start_seen <= 1'b1;
    end
  end

  // R2
  idle_silent_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !start_seen |-> (!sync && !sdata_out && !fifo_wr_en));

  // R4
  sync_len_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(sync) |-> sync_run == 16);

  // R8
  wr_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    fifo_wr_en |=> !fifo_wr_en);

  // R9
  no_write_full_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(fifo_wr_en) |-> !$past(fifo_full));

  // R7
  cap_after_cfg_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    fifo_wr_en |-> rises > N_CMDS);
endmodule

bind codec_capture_ctl codec_capture_ctl_chk #(.N_CMDS(4)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .start_async(start_async), .sync(sync),
  .sdata_out(sdata_out), .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en));

// File: tb/tb_codec_capture_ctl.sv
`timescale 1ns/1ps
module tb_codec_capture_ctl;
  localparam int CLK_PERIOD = 82;
  localparam int Q = CLK_PERIOD / 4;

  logic bit_clk = 0, rst_n = 0, start_async = 0, sdata_in = 0, fifo_full = 0;
  logic sync, sdata_out, fifo_wr_en;
  logic [15:0] fifo_wr_data;
  int total = 0, bad = 0;
  bit done = 0;

  codec_capture_ctl dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .start_async(start_async),
    .sdata_in(sdata_in), .sync(sync), .sdata_out(sdata_out),
    .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data));

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  logic sb [0:255];
  logic ob [0:255];
  logic [15:0] wd [0:7];
  int wk [0:7];
  int nw;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic in_bit(int k, logic [19:0] l, logic [19:0] r, logic fill);
    if (k >= 56 && k <= 75) return l[75-k];
    if (k >= 76 && k <= 95) return r[95-k];
    return fill;
  endfunction

  function automatic logic exp_out(int k, bit pend, logic [6:0] a, logic [15:0] d);
    logic [19:0] w1, w2;
    w1 = {1'b0, a, 12'b0};
    w2 = {d, 4'b0};
    if (k == 0) return 1'b1;
    if (k == 1 || k == 2) return pend;
    if (k < 16) return 1'b0;
    if (k < 36) return pend ? w1[35-k] : 1'b0;
    if (k < 56) return pend ? w2[55-k] : 1'b0;
    return 1'b0;
  endfunction

  // entry and exit: P/4 after the rising edge that starts frame bit 0
  task automatic do_frame(input bit pend, input logic [6:0] a, input logic [15:0] d,
                          input logic [19:0] l, input logic [19:0] r, input logic fill,
                          input bit cap, input bit drop_l, input bit drop_r,
                          input string wreq);
    int bad_sync, bad_tag, bad_slot, first;
    int ne;
    logic [15:0] ed [0:1];
    int ek [0:1];
    nw = 0;
    for (int k = 0; k < 256; k++) begin
      sdata_in  = in_bit(k, l, r, fill);
      fifo_full = (drop_l && k == 75) || (drop_r && k == 95);
      sb[k] = sync;
      ob[k] = sdata_out;
      if (fifo_wr_en && nw < 8) begin wd[nw] = fifo_wr_data; wk[nw] = k; nw++; end
      @(posedge bit_clk); #(Q);
    end
    fifo_full = 0;
    bad_sync = 0; bad_tag = 0; bad_slot = 0; first = -1;
    for (int k = 0; k < 256; k++) begin
      if (sb[k] !== (k < 16)) begin bad_sync++; if (first < 0) first = k; end
      if (ob[k] !== exp_out(k, pend, a, d)) begin
        if (k < 16) bad_tag++; else bad_slot++;
      end
    end
    check(bad_sync == 0, "R4", "sync bits wrong", bad_sync, 0);
    check(bad_tag == 0, "R5", "tag bits wrong", bad_tag, 0);
    check(bad_slot == 0, "R6", "slot bits wrong", bad_slot, 0);
    ne = 0;
    if (cap && !drop_l) begin ed[ne] = l[19:4]; ek[ne] = 76; ne++; end
    if (cap && !drop_r) begin ed[ne] = r[19:4]; ek[ne] = 96; ne++; end
    check(nw == ne, wreq, "write count", nw, ne);
    if (nw == ne)
      for (int i = 0; i < ne; i++) begin
        check(wd[i] === ed[i], wreq, "write data", wd[i], ed[i]);
        check(wk[i] == ek[i], wreq, "write bit", wk[i], ek[i]);
      end
  endtask

  task automatic test_reset();
    #(Q);
    check(sync === 0 && sdata_out === 0 && fifo_wr_en === 0, "R1", "in reset",
          {sync, sdata_out, fifo_wr_en}, 0);
    @(posedge bit_clk); #(Q); rst_n = 1;
    @(posedge bit_clk); #(Q);
    check(sync === 0 && sdata_out === 0 && fifo_wr_en === 0, "R1", "after reset",
          {sync, sdata_out, fifo_wr_en}, 0);
  endtask

  task automatic test_idle();
    int hits = 0;
    for (int i = 0; i < 300; i++) begin
      sdata_in = i[0];
      if (sync !== 0 || sdata_out !== 0 || fifo_wr_en !== 0) hits++;
      @(posedge bit_clk); #(Q);
    end
    check(hits == 0, "R2", "activity before start", hits, 0);
  endtask

  task automatic test_start();
    logic s1, s2, s3;
    start_async = 1;
    @(posedge bit_clk); #(Q); s1 = sync;
    @(posedge bit_clk); #(Q); s2 = sync;
    @(posedge bit_clk); #(Q); s3 = sync;
    check(s1 === 0 && s2 === 0 && s3 === 1, "R3", "sync rise timing",
          {s1, s2, s3}, 3'b001);
  endtask

  task automatic test_config();
    logic [6:0]  a [0:3];
    logic [15:0] d [0:3];
    a[0] = 7'h02; d[0] = 16'h0000;
    a[1] = 7'h0E; d[1] = 16'h0008;
    a[2] = 7'h1A; d[2] = 16'h0000;
    a[3] = 7'h1C; d[3] = 16'h0F0F;
    for (int i = 0; i < 4; i++)
      do_frame(1, a[i], d[i], 20'hABCDE, 20'h13579, 1'b0, 0, 0, 0, "R7");
  endtask

  task automatic test_capture();
    do_frame(0, 0, 0, 20'hABCDE, 20'h12345, 1'b0, 1, 0, 0, "R8");
    do_frame(0, 0, 0, 20'h00000, 20'hFFFFF, 1'b0, 1, 0, 0, "R8");
    do_frame(0, 0, 0, 20'h8000F, 20'h7FFF0, 1'b0, 1, 0, 0, "R7");
  endtask

  task automatic test_ignored();
    do_frame(0, 0, 0, 20'h00000, 20'h00000, 1'b1, 1, 0, 0, "R10");
    do_frame(0, 0, 0, 20'h5A5A5, 20'hA5A5A, 1'b1, 1, 0, 0, "R10");
  endtask

  task automatic test_full();
    do_frame(0, 0, 0, 20'h11111, 20'h22222, 1'b0, 1, 1, 0, "R9");
    do_frame(0, 0, 0, 20'h33333, 20'h44444, 1'b0, 1, 0, 1, "R9");
    do_frame(0, 0, 0, 20'h55555, 20'h66666, 1'b0, 1, 0, 0, "R9");
  endtask

  initial begin
    test_reset();
    test_idle();
    test_start();
    test_config();
    test_capture();
    test_ignored();
    test_full();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule